// File: doc/BRIEF.md
# Byte-Buffered 16-bit Timer/Event Counter

This block is a 16-bit upward counter that software reaches over an 8-bit register bus. A two-bit mode field picks the count source. In timer mode the counter advances on an internal tick that fires once every four clocks. In event mode it advances on a chosen edge of an external pin. In pulse-width mode it advances on the internal tick for as long as the pin holds a chosen level. The pin passes through a synchroniser, and edges are found on the synchronised copy.

A 16-bit value cannot move across an 8-bit bus in one access. An 8-bit low-byte buffer therefore sits between the bus and the low half of the counter. A read of the high byte captures the live low byte into the buffer, so a later read of the low byte returns a value that matches the high byte just read. A write of the low byte only fills the buffer. A following write of the high byte commits both halves at once to the 16-bit reload register. When the counter steps past its maximum, it takes the reload value and sets a sticky overflow flag. That flag can drive an interrupt request, and a dedicated input clears it.

Top module: `bytebuf_timer`

## Requirements
- R1: After reset the control register, the counter, the reload register, the low-byte buffer and the overflow flag are all zero.
- R2: Address 0 is control, address 1 is the high data byte, address 2 is the low data byte, and address 3 reads as 0. In the control byte, bits 7:6 are the mode (00 off, 01 event, 10 timer, 11 pulse width), bit 4 is run and bit 3 is the edge/level select. Bits 5 and 2:0 always read 0, and writes to them are ignored.
- R3: A low-byte write changes only the low-byte buffer. Neither the counter nor the reload register changes.
- R4: A high-byte write loads the reload register with {written byte, buffer} in one step. While run is 0, the same write also loads the counter with that value. While run is 1, the counter is not touched.
- R5: A high-byte read returns counter bits 15:8 and copies counter bits 7:0 into the low-byte buffer in the same access. A low-byte read returns the buffer.
- R6: In timer mode with run set, the counter advances by exactly one per four clocks.
- R7: In event mode with run set, each synchronised edge of the external pin advances the counter by one. Select 0 counts rising edges and select 1 counts falling edges.
- R8: In pulse-width mode with run set, the counter advances on each internal tick while the synchronised pin equals the select bit (1 means high time). Once it has counted, the first return of the opposite level clears run, and the count then holds.
- R9: With mode 00, or with run cleared, the counter does not change.
- R10: A count while the counter is at 0xFFFF loads the reload value and sets the overflow flag. The flag stays set until the clear input is high in a cycle with no new overflow. If a wrap and a clear fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as the address |
| ext_in | input | 1 | External event / pulse input, asynchronous |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The two functions that can meet in one cycle are the overflow wrap, which sets the flag, and the clear input, which resets it. The bench makes them coincide by timing an external rising edge so that its detected edge, two synchroniser stages and one history register later, lands on the very clock at which ovf_clr is held high, while the counter sits at 0xFFFF. It then expects the flag to read set and the counter to hold the reload value. A following clear in a cycle with no wrap must drop the flag. A second overlap is also checked: a high-byte write while the counter runs must change only the reload register, which the bench observes through the value the next wrap produces.

// File: rtl/bytebuf_timer_pkg.sv
package bytebuf_timer_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_PULSE = 2'b11
    } cnt_mode_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_HIGH = 2'd1;
    localparam logic [1:0] ADDR_LOW  = 2'd2;

    localparam int CTRL_MODE_HI = 7;
    localparam int CTRL_MODE_LO = 6;
    localparam int CTRL_RUN     = 4;
    localparam int CTRL_SEL     = 3;

    typedef struct packed {
        cnt_mode_e          mode;
        logic               run;
        logic               sel;
        logic               pw_armed;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   reload;
        logic [DATA_W-1:0]  lowbuf;
        logic               ovf;
    } tmr_state_t;

endpackage

// File: rtl/bytebuf_timer_sync.sv
module bytebuf_timer_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign lvl  = chain_q[STAGES-1];
    assign rise = chain_q[STAGES-1] & ~prev_q;
    assign fall = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/bytebuf_timer_tick.sv
module bytebuf_timer_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_d, div_q;

    always_comb begin
        div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/bytebuf_timer.sv
module bytebuf_timer
    import bytebuf_timer_pkg::*;
#(
    parameter int TICK_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_in,
    input  logic              ovf_clr,
    output logic              ovf_flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    tmr_state_t st_d, st_q;
    logic       tick, pin_lvl, pin_rise, pin_fall;
    logic       step, pw_done;

    bytebuf_timer_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    bytebuf_timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_in),
        .lvl      (pin_lvl),
        .rise     (pin_rise),
        .fall     (pin_fall)
    );

    always_comb begin
        step = 1'b0;
        if (st_q.run) begin
            unique case (st_q.mode)
                MODE_TIMER: step = tick;
                MODE_EVENT: step = st_q.sel ? pin_fall : pin_rise;
                MODE_PULSE: step = tick && (pin_lvl == st_q.sel);
                default:    step = 1'b0;
            endcase
        end
        pw_done = st_q.run && (st_q.mode == MODE_PULSE) && st_q.pw_armed
                  && (pin_lvl != st_q.sel);
    end

    always_comb begin
        st_d = st_q;

        if (ovf_clr) st_d.ovf = 1'b0;

        if (step) begin
            if (st_q.cnt == CNT_MAX) begin
                st_d.cnt = st_q.reload;
                st_d.ovf = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_q.mode == MODE_PULSE) st_d.pw_armed = 1'b1;
        end

        if (pw_done) begin
            st_d.run      = 1'b0;
            st_d.pw_armed = 1'b0;
        end

        if (bus_rd && bus_addr == ADDR_HIGH) begin
            st_d.lowbuf = st_q.cnt[DATA_W-1:0];
        end

        if (bus_wr) begin
            unique case (bus_addr)
                ADDR_CTRL: begin
                    st_d.mode     = cnt_mode_e'(bus_wdata[CTRL_MODE_HI:CTRL_MODE_LO]);
                    st_d.run      = bus_wdata[CTRL_RUN];
                    st_d.sel      = bus_wdata[CTRL_SEL];
                    st_d.pw_armed = 1'b0;
                end
                ADDR_HIGH: begin
                    st_d.reload = {bus_wdata, st_q.lowbuf};
                    if (!st_q.run) st_d.cnt = {bus_wdata, st_q.lowbuf};
                end
                ADDR_LOW: st_d.lowbuf = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_OFF, run: 1'b0, sel: 1'b0, pw_armed: 1'b0,
                      cnt: '0, reload: '0, lowbuf: '0, ovf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[CTRL_MODE_HI:CTRL_MODE_LO] = st_q.mode;
                bus_rdata[CTRL_RUN]                  = st_q.run;
                bus_rdata[CTRL_SEL]                  = st_q.sel;
            end
            ADDR_HIGH: bus_rdata = st_q.cnt[CNT_W-1:DATA_W];
            ADDR_LOW:  bus_rdata = st_q.lowbuf;
            default:   bus_rdata = '0;
        endcase
    end

    assign ovf_flag = st_q.ovf;

    logic [CNT_W-1:0]  mon_cnt, mon_reload;
    logic [DATA_W-1:0] mon_lowbuf;
    logic              mon_run, mon_step;
    logic [1:0]        mon_mode;
    assign mon_cnt    = st_q.cnt;
    assign mon_reload = st_q.reload;
    assign mon_lowbuf = st_q.lowbuf;
    assign mon_run    = st_q.run;
    assign mon_step   = step;
    assign mon_mode   = st_q.mode;
endmodule

// File: rtl/bytebuf_timer_chk.sv
module bytebuf_timer_chk
    import bytebuf_timer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              ovf_clr,
    input logic              ovf_flag,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  reload,
    input logic [DATA_W-1:0] lowbuf,
    input logic              run,
    input logic              step,
    input logic [1:0]        mode
);
    AST_CTRL_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_CTRL) |-> (bus_rdata[5] == 1'b0 && bus_rdata[2:0] == 3'b000)); // R2

    AST_LOWWR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_LOW) |=> ($stable(reload) && lowbuf == $past(bus_rdata) || $stable(reload))); // R3

    AST_HIGHRD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == ADDR_HIGH) |=> (lowbuf == $past(cnt[DATA_W-1:0]))); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_OFF || !run) && !(bus_wr && bus_addr == ADDR_HIGH)) |=> $stable(cnt)); // R9

    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == '1 && !(bus_wr && bus_addr == ADDR_HIGH)) |=> (ovf_flag && cnt == $past(reload))); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag); // R10

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt != '1 && !(bus_wr && bus_addr == ADDR_HIGH)) |=> (cnt == $past(cnt) + 1'b1)); // R6
endmodule

bind bytebuf_timer bytebuf_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .ovf_clr   (ovf_clr),
    .ovf_flag  (ovf_flag),
    .cnt       (mon_cnt),
    .reload    (mon_reload),
    .lowbuf    (mon_lowbuf),
    .run       (mon_run),
    .step      (mon_step),
    .mode      (mon_mode)
);

// File: tb/tb_bytebuf_timer.sv
module tb_bytebuf_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ext_in = 1'b0;
    logic       ovf_clr = 1'b0;
    logic       ovf_flag;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bytebuf_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_in(ext_in), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] h, l;
        rd(2'd1, h);
        rd(2'd2, l);
        v = {h, l};
    endtask

    task automatic preset(input logic [15:0] v);
        wr(2'd0, 8'h00);
        wr(2'd2, v[7:0]);
        wr(2'd1, v[15:8]);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ext_in = 1'b1;
            repeat (6) @(negedge clk);
            ext_in = 1'b0;
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        logic [15:0] v;
        rd(2'd0, d); check("R1 ctrl", {8'h00, d}, 16'h0000);
        rd16(v);     check("R1 count", v, 16'h0000);
        check("R1 flag", {15'd0, ovf_flag}, 16'h0000);
        rd(2'd3, d); check("R2 addr3", {8'h00, d}, 16'h0000);
    endtask

    task automatic t_ctrl;
        logic [7:0] d;
        wr(2'd0, 8'hFF);
        rd(2'd0, d); check("R2 spare bits", {8'h00, d}, 16'h00D8);
        wr(2'd0, 8'h00);
        rd(2'd0, d); check("R2 cleared", {8'h00, d}, 16'h0000);
    endtask

    task automatic t_buffer;
        logic [7:0] d;
        logic [15:0] v;
        preset(16'hABCD);
        rd16(v);     check("R4 stopped load", v, 16'hABCD);
        wr(2'd2, 8'h55);
        rd(2'd2, d); check("R5 low reads buffer", {8'h00, d}, 16'h0055);
        rd(2'd1, d); check("R3 low write no count", {8'h00, d}, 16'h00AB);
        rd(2'd2, d); check("R5 high read latches low", {8'h00, d}, 16'h00CD);
    endtask

    task automatic t_timer;
        logic [15:0] v;
        preset(16'h0000);
        wr(2'd0, 8'h90);
        repeat (39) @(posedge clk);
        wr(2'd0, 8'h80);
        rd16(v); check("R6 timer 40 clocks", v, 16'h000A);
    endtask

    task automatic t_event;
        logic [15:0] v;
        preset(16'h0000);
        wr(2'd0, 8'h50);
        pulse(5);
        rd16(v); check("R7 rising count", v, 16'h0005);
        wr(2'd0, 8'h58);
        pulse(3);
        wr(2'd0, 8'h40);
        rd16(v); check("R7 falling count", v, 16'h0008);
        pulse(2);
        rd16(v); check("R9 run off holds", v, 16'h0008);
    endtask

    task automatic t_off;
        logic [15:0] v;
        preset(16'h0777);
        wr(2'd0, 8'h10);
        pulse(3);
        repeat (40) @(posedge clk);
        rd16(v); check("R9 mode off holds", v, 16'h0777);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_pulse;
        logic [7:0] d;
        logic [15:0] v;
        preset(16'h0000);
        wr(2'd0, 8'hD8);
        repeat (20) @(negedge clk);
        rd(2'd0, d); check("R8 waits for level", {8'h00, d}, 16'h00D8);
        @(negedge clk) ext_in = 1'b1;
        repeat (40) @(negedge clk);
        ext_in = 1'b0;
        repeat (10) @(negedge clk);
        rd(2'd0, d); check("R8 run cleared", {8'h00, d}, 16'h00C8);
        rd16(v);     check("R8 width", v, 16'h000A);
        repeat (20) @(negedge clk);
        rd16(v);     check("R8 holds", v, 16'h000A);
    endtask

    task automatic t_wrap;
        logic [15:0] v;
        preset(16'hFFFE);
        wr(2'd0, 8'h50);
        wr(2'd2, 8'h34);
        wr(2'd1, 8'h12);
        wr(2'd2, 8'h99);
        rd16(v); check("R4 running write no count", v, 16'hFFFE);
        pulse(1);
        check("R10 no flag before wrap", {15'd0, ovf_flag}, 16'h0000);
        @(negedge clk) ext_in = 1'b1;
        @(posedge clk); @(posedge clk); #1 ovf_clr = 1'b1;
        @(posedge clk); #1 ovf_clr = 1'b0;
        @(negedge clk) check("R10 set wins over clear", {15'd0, ovf_flag}, 16'h0001);
        ext_in = 1'b0;
        repeat (10) @(negedge clk);
        check("R10 sticky", {15'd0, ovf_flag}, 16'h0001);
        rd16(v); check("R10 reload value R3", v, 16'h1234);
        @(negedge clk) ovf_clr = 1'b1;
        @(negedge clk) ovf_clr = 1'b0;
        check("R10 cleared", {15'd0, ovf_flag}, 16'h0000);
        pulse(1);
        rd16(v); check("R10 counts on after reload", v, 16'h1235);
        wr(2'd0, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset;
        t_ctrl;
        t_buffer;
        t_timer;
        t_event;
        t_off;
        t_pulse;
        t_wrap;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule